// File: doc/BRIEF.md
# Card Interrupt Output Aggregator

This block gathers the event flags of a smart-card interface and folds them into one open-drain pin that serves either as an interrupt line or as a card-present indication. Each event is held in a sticky flag. A flag is set by a hardware event edge or by a software write. It is cleared by an acknowledged-read strobe for the status group that holds it. The flags are exposed in two groups. The host reads them through the serial interface, which lies outside this block.

A mode select input picks the meaning of the pin. In the shared-interrupt mode the pin floats high and is pulled low while any flag is pending. Several devices can wire their pins together, and the host polls each device to find the source. In the presence mode the pin is released high only while a card is detected and no error flag is pending. The check for an answer-to-reset timeout has its own enable: with the enable low, a counter overflow does not raise that flag.

Top module: `card_irq_merge`

## Requirements
- R1: After reset all five flags are 0, and with `mode_sel`=0 the pin is released (`pin_pull_low`=0, `pin_level`=1).
- R2: A change of `card_present` in either direction between two consecutive clock edges sets `cfg_flags[0]` (insertion/extraction) at the edge where the new level is sampled.
- R3: A rising edge of `dcdc_ready` sets `stat_flags[0]`, a rising edge of `ovc_event` sets `stat_flags[1]`, and a rising edge of `vout_bad` sets `cfg_flags[1]`. Each flag is set at the edge where the input is first sampled high.
- R4: A rising edge of `atr_timeout` sets `cfg_flags[2]` only if `atr_chk_en` is 1 in that cycle. With `atr_chk_en`=0 the flag does not change.
- R5: When `sw_set_valid` is 1, each bit of `sw_set_bits` that is 1 sets the `cfg_flags` bit at the same position: bit 0 insertion, bit 1 voltage error, bit 2 timeout error.
- R6: `rd_ack_stat` clears both `stat_flags` bits and `rd_ack_cfg` clears all three `cfg_flags` bits at the next edge. The strobes act in both modes.
- R7: When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R8: A flag with no set and no clear keeps its value. In particular, an event input that returns low does not clear its flag.
- R9: With `mode_sel`=0, `pin_pull_low` is 1 exactly when at least one of the five flags is 1.
- R10: With `mode_sel`=1, `pin_pull_low` is 0 exactly when `card_present` was 1 at the last clock edge and `stat_flags[1]`, `cfg_flags[1]` and `cfg_flags[2]` are all 0. `pin_level` is always the inverse of `pin_pull_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | 0: shared interrupt, 1: card-present level |
| atr_chk_en | input | 1 | Enables the answer-to-reset timeout event |
| card_present | input | 1 | Card detect level |
| dcdc_ready | input | 1 | Card supply converter has settled |
| ovc_event | input | 1 | Over-current on the card supply |
| vout_bad | input | 1 | Card supply voltage out of range |
| atr_timeout | input | 1 | Card clock counter overflowed before the answer to reset |
| sw_set_valid | input | 1 | Software write strobe for the settable flags |
| sw_set_bits | input | 3 | Flags to set: bit0 insertion, bit1 voltage, bit2 timeout |
| rd_ack_stat | input | 1 | Acknowledged read of the status group |
| rd_ack_cfg | input | 1 | Acknowledged read of the configuration flag group |
| stat_flags | output | 2 | bit0 supply settled, bit1 over-current |
| cfg_flags | output | 3 | bit0 insertion, bit1 voltage error, bit2 timeout error |
| pin_pull_low | output | 1 | Open-drain pull-down enable for the shared pin |
| pin_level | output | 1 | Level the pin shows when only this device drives it |

## Verification
The hardest case to reach is a clear strobe that lands in the same cycle as a new event edge on a flag the strobe is clearing. This requires an input toggle and a read acknowledge to line up. A directed step raises `vout_bad` together with `rd_ack_cfg` while the insertion flag is pending. The random phase then toggles inputs and strobes often enough to repeat such collisions many times, in both pin modes. The timeout flag with its enable low is driven directly, and then again with software writes mixed in.

// File: rtl/card_irq_merge.sv
module card_irq_merge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sel,
  input  logic       atr_chk_en,
  input  logic       card_present,
  input  logic       dcdc_ready,
  input  logic       ovc_event,
  input  logic       vout_bad,
  input  logic       atr_timeout,
  input  logic       sw_set_valid,
  input  logic [2:0] sw_set_bits,
  input  logic       rd_ack_stat,
  input  logic       rd_ack_cfg,
  output logic [1:0] stat_flags,
  output logic [2:0] cfg_flags,
  output logic       pin_pull_low,
  output logic       pin_level
);

  // sampled inputs: {timeout, voltage, overcurrent, settled, present}
  logic [4:0] in_q;
  logic [4:0] in_now;
  logic [4:0] rise;
  logic [1:0] stat_set;
  logic [2:0] cfg_set;
  logic       err_pend;

  assign in_now = {atr_timeout, vout_bad, ovc_event, dcdc_ready, card_present};
  assign rise   = in_now & ~in_q;

  assign stat_set = {rise[2], rise[1]};
  assign cfg_set  = {rise[4] & atr_chk_en, rise[3], in_now[0] ^ in_q[0]}
                  | (sw_set_bits & {3{sw_set_valid}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q       <= '0;
      stat_flags <= '0;
      cfg_flags  <= '0;
    end else begin
      in_q       <= in_now;
      stat_flags <= (stat_flags & ~{2{rd_ack_stat}}) | stat_set;
      cfg_flags  <= (cfg_flags & ~{3{rd_ack_cfg}}) | cfg_set;
    end
  end

  assign err_pend     = stat_flags[1] | cfg_flags[1] | cfg_flags[2];
  assign pin_pull_low = mode_sel ? ~(in_q[0] & ~err_pend)
                                 : ((|stat_flags) | (|cfg_flags));
  assign pin_level    = ~pin_pull_low;

  assert_presence_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (card_present != in_q[0]) |=> cfg_flags[0]);

  assert_ovc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack_stat && !ovc_event) |=> !stat_flags[1]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack_cfg && sw_set_valid && sw_set_bits[1]) |=> cfg_flags[1]);

  assert_atr_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!atr_chk_en && !(sw_set_valid && sw_set_bits[2]) && !cfg_flags[2]) |=> !cfg_flags[2]);

  assert_shared_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && stat_flags == 2'b00 && cfg_flags == 3'b000) |-> !pin_pull_low);

  assert_shared_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && (stat_flags != 2'b00 || cfg_flags != 3'b000)) |-> pin_pull_low);

  assert_presence_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && (stat_flags[1] || cfg_flags[2:1] != 2'b00)) |-> !pin_level);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flags[0] && !rd_ack_stat) |=> stat_flags[0]);

endmodule

// File: tb/tb_card_irq_merge.sv
`timescale 1ns/1ps
module tb_card_irq_merge;
  logic clk = 0;
  logic rst_n = 0;
  logic mode_sel = 0, atr_chk_en = 0, card_present = 0, dcdc_ready = 0;
  logic ovc_event = 0, vout_bad = 0, atr_timeout = 0, sw_set_valid = 0;
  logic [2:0] sw_set_bits = 0;
  logic rd_ack_stat = 0, rd_ack_cfg = 0;
  logic [1:0] stat_flags;
  logic [2:0] cfg_flags;
  logic pin_pull_low, pin_level;

  int n_chk = 0, n_bad = 0;
  logic [4:0] m_q = 0;
  logic [1:0] m_stat = 0;
  logic [2:0] m_cfg = 0;

  always #2 clk = ~clk;

  card_irq_merge dut (.*);

  function automatic logic exp_pull(logic md, logic cpq, logic [1:0] st, logic [2:0] cf);
    if (md) return !(cpq && !(st[1] || cf[1] || cf[2]));
    return (st != 0) || (cf != 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs are set at a negedge; this advances one edge and compares
  task automatic tick(input string tag);
    logic [4:0] now, rs;
    logic [1:0] ns;
    logic [2:0] nc;
    logic ep;
    now = {atr_timeout, vout_bad, ovc_event, dcdc_ready, card_present};
    rs = now & ~m_q;
    ns = (rd_ack_stat ? 2'b00 : m_stat) | {rs[2], rs[1]};
    nc = (rd_ack_cfg ? 3'b000 : m_cfg) | {rs[4] & atr_chk_en, rs[3], now[0] ^ m_q[0]}
         | (sw_set_valid ? sw_set_bits : 3'b000);
    @(posedge clk); #1;
    m_q = now; m_stat = ns; m_cfg = nc;
    ep = exp_pull(mode_sel, m_q[0], m_stat, m_cfg);
    chk(stat_flags == m_stat, tag, stat_flags, m_stat);
    chk(cfg_flags == m_cfg, tag, cfg_flags, m_cfg);
    chk(pin_pull_low == ep && pin_level == !ep, tag, {pin_pull_low, pin_level}, {ep, !ep});
    @(negedge clk);
    sw_set_valid = 0; rd_ack_stat = 0; rd_ack_cfg = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7001));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #0;
    chk(stat_flags == 0 && cfg_flags == 0, "R1 flags", {stat_flags, cfg_flags}, 0);
    chk(pin_pull_low == 0 && pin_level == 1, "R1 pin", pin_pull_low, 0);

    card_present = 1; tick("R2 insert R9");
    tick("R8 hold");
    rd_ack_cfg = 1; tick("R6 cfg clear");
    card_present = 0; tick("R2 extract");
    rd_ack_cfg = 1; vout_bad = 1; tick("R7 set beats clear R3");
    vout_bad = 0; tick("R8 input low keeps flag");
    rd_ack_cfg = 1; tick("R6");
    atr_chk_en = 0; atr_timeout = 1; tick("R4 gated off");
    atr_timeout = 0; tick("R4");
    atr_chk_en = 1; atr_timeout = 1; tick("R4 enabled");
    atr_timeout = 0; rd_ack_cfg = 1; tick("R6");
    sw_set_valid = 1; sw_set_bits = 3'b101; tick("R5 sw set");
    rd_ack_cfg = 1; sw_set_valid = 1; sw_set_bits = 3'b010; tick("R7 R5");
    rd_ack_cfg = 1; tick("R6");
    dcdc_ready = 1; tick("R3 settled");
    ovc_event = 1; tick("R3 overcurrent");
    rd_ack_stat = 1; tick("R6 stat clear");
    mode_sel = 1; tick("R10 no card");
    card_present = 1; tick("R10 card present");
    rd_ack_cfg = 1; tick("R10 present no error");
    ovc_event = 0; tick("R10");
    ovc_event = 1; tick("R10 error pulls low");
    rd_ack_stat = 1; ovc_event = 0; tick("R10 released");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) card_present = ~card_present;
      if ($urandom_range(7) == 0) dcdc_ready = ~dcdc_ready;
      if ($urandom_range(7) == 0) ovc_event = ~ovc_event;
      if ($urandom_range(7) == 0) vout_bad = ~vout_bad;
      if ($urandom_range(7) == 0) atr_timeout = ~atr_timeout;
      if ($urandom_range(19) == 0) atr_chk_en = ~atr_chk_en;
      if ($urandom_range(49) == 0) mode_sel = ~mode_sel;
      rd_ack_stat = ($urandom_range(5) == 0);
      rd_ack_cfg = ($urandom_range(5) == 0);
      sw_set_valid = ($urandom_range(9) == 0);
      sw_set_bits = 3'($urandom_range(7));
      tick("random R3 R9 R10");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule